// File: doc/BRIEF.md
# Dual-Phase PWM Generator with Dead Time

This block drives the two switches of a push-pull or half-bridge power stage. It produces two active-high gate-enable outputs. Both outputs carry pulses of the same programmable width. Phase B's pulse starts exactly half a period after phase A's pulse starts. The requested width is clamped so that both outputs are low together for at least a programmable dead-time count before either output rises. The two switches therefore never conduct at the same time, even when the width asks for close to 50%.

Period, width and dead time are written through a small configuration port into shadow registers. The active copies are refreshed only when the period counter wraps to zero, or while the block is disabled. A change therefore never cuts or stretches a pulse that is already under way. The `en` input stops the stage: both outputs fall at the next clock edge and the counter restarts from zero. Both gate lines come straight from flip-flops.

Top module: `dual_phase_pwm`

## Requirements
- R1: The counter runs through 0 .. P-1 and then wraps. P is the programmed period with bit 0 cleared, and it is raised to 4 if the result is smaller than 4.
- R2: `pwm_a` rises one edge after the counter reads 0. It stays high for Weff consecutive cycles, and its rising edges are P cycles apart.
- R3: `pwm_b` rises P/2 cycles after `pwm_a` rises and stays high for the same Weff cycles.
- R4: The effective dead time is Deff = max(D,1). The effective width is Weff = min(W, P/2 - Deff), or 0 when P/2 <= Deff.
- R5: `pwm_a` and `pwm_b` are never high in the same cycle. Every rise of either output is preceded by at least Deff cycles in which both outputs are low.
- R6: A write made during a period does not change that period's pulses. It takes effect from the next wrap to 0.
- R7: When Weff is 0, both outputs stay low for the whole period.
- R8: While `en` is low, both outputs are low from the next edge and the counter holds at 0. The first edge that samples `en` high starts a new period, and `pwm_a` rises at that edge when Weff > 0.
- R9: `cfg_ready` is always high, so every cycle with `cfg_valid` high is one accepted write. `cfg_sel` selects the target: 0 is period, 1 is width, 2 is dead time. Value 3 is ignored and changes nothing.
- R10: After reset, both outputs are low, the period is 16, the width is 0 and the dead time is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable. Low forces both outputs off and clears the counter |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_ready | output | 1 | Always high; the port never back-pressures |
| cfg_sel | input | 2 | Register select: 0 period, 1 width, 2 dead time, 3 none |
| cfg_data | input | CW (12) | Value to write |
| pwm_a | output | 1 | Phase A gate enable |
| pwm_b | output | 1 | Phase B gate enable, offset by half a period |

## Verification
A configuration write becomes visible only at the next counter wrap. The bench therefore writes with `en` low and measures over whole periods, or, for R6, measures the remainder of the current period before it expects the new width. An output changes one edge after the counter value that causes the change, so `pwm_a` is expected high at the first falling edge after the rising edge that samples `en` high, and low at the first falling edge after the edge that samples `en` low. All samples are taken at falling edges, so pulse lengths, rise-to-rise spacing and dead gaps are counted in whole cycles on a fixed grid.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_WIDTH  = 2'd1,
    SEL_DEAD   = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;

  localparam int unsigned NUM_PHASES = 2;
  localparam int unsigned MIN_PERIOD = 4;
endpackage

// File: rtl/dpwm_shadow.sv
module dpwm_shadow
  import dpwm_pkg::*;
#(
  parameter int unsigned CW       = 12,
  parameter int unsigned PER_RST  = 16,
  parameter int unsigned DEAD_RST = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          load,
  output logic [CW-1:0] act_period,
  output logic [CW-1:0] act_half,
  output logic [CW-1:0] act_width,
  output logic [CW-1:0] act_dead
);
  localparam logic [CW-1:0] P_RST = CW'(PER_RST);
  localparam logic [CW-1:0] D_RST = CW'(DEAD_RST);
  localparam logic [CW-1:0] P_MIN = CW'(MIN_PERIOD);

  logic [CW-1:0] sh_period, sh_width, sh_dead;
  logic [CW-1:0] p_even, p_eff, half_eff, d_eff, w_max, w_eff;
  cfg_sel_e      sel;

  assign sel = cfg_sel_e'(wr_sel);

  // shadow registers take writes at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_period <= P_RST;
      sh_width  <= '0;
      sh_dead   <= D_RST;
    end else if (wr_en) begin
      case (sel)
        SEL_PERIOD: sh_period <= wr_data;
        SEL_WIDTH:  sh_width  <= wr_data;
        SEL_DEAD:   sh_dead   <= wr_data;
        default:    ;
      endcase
    end
  end

  // legalise the shadow values before they become active
  always_comb begin
    p_even   = {sh_period[CW-1:1], 1'b0};
    p_eff    = (p_even < P_MIN) ? P_MIN : p_even;
    half_eff = p_eff >> 1;
    d_eff    = (sh_dead == '0) ? CW'(1) : sh_dead;
    w_max    = (half_eff > d_eff) ? (half_eff - d_eff) : '0;
    w_eff    = (sh_width > w_max) ? w_max : sh_width;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period <= P_RST;
      act_half   <= P_RST >> 1;
      act_width  <= '0;
      act_dead   <= D_RST;
    end else if (load) begin
      act_period <= p_eff;
      act_half   <= half_eff;
      act_width  <= w_eff;
      act_dead   <= d_eff;
    end
  end
endmodule

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  assign wrap = (cnt == period - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!en || wrap)
      cnt <= '0;
    else
      cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/dpwm_phase_out.sv
module dpwm_phase_out #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] width,
  output logic          pwm
);
  logic [CW-1:0] rel;
  logic          in_win;

  assign rel    = cnt - start;
  assign in_win = (cnt >= start) && (rel < width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pwm <= 1'b0;
    else
      pwm <= en & in_win;
  end
endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
  import dpwm_pkg::*;
#(
  parameter int unsigned CW       = 12,
  parameter int unsigned PER_RST  = 16,
  parameter int unsigned DEAD_RST = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic [1:0]    cfg_sel,
  input  logic [CW-1:0] cfg_data,
  output logic          pwm_a,
  output logic          pwm_b
);
  logic [CW-1:0] act_period, act_half, act_width, act_dead;
  logic [CW-1:0] cnt;
  logic          wrap;
  logic          load;
  logic [NUM_PHASES-1:0] pwm_vec;

  assign cfg_ready = 1'b1;
  assign load      = !en || wrap;

  dpwm_shadow #(.CW(CW), .PER_RST(PER_RST), .DEAD_RST(DEAD_RST)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_valid & cfg_ready),
    .wr_sel     (cfg_sel),
    .wr_data    (cfg_data),
    .load       (load),
    .act_period (act_period),
    .act_half   (act_half),
    .act_width  (act_width),
    .act_dead   (act_dead)
  );

  dpwm_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .period (act_period),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  for (genvar ph = 0; ph < NUM_PHASES; ph++) begin : g_phase
    logic [CW-1:0] start;
    assign start = (ph == 0) ? '0 : act_half;
    dpwm_phase_out #(.CW(CW)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .cnt   (cnt),
      .start (start),
      .width (act_width),
      .pwm   (pwm_vec[ph])
    );
  end

  assign pwm_a = pwm_vec[0];
  assign pwm_b = pwm_vec[1];
endmodule

// File: rtl/dual_phase_pwm_chk.sv
module dual_phase_pwm_chk #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          cfg_ready,
  input logic          pwm_a,
  input logic          pwm_b,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] act_period,
  input logic [CW-1:0] act_half,
  input logic [CW-1:0] act_width,
  input logic [CW-1:0] act_dead
);
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_a && pwm_b));

  // R8
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_a && !pwm_b));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < act_period);

  // R2
  a_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_a) |-> ($past(cnt) == '0));

  // R3
  b_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_b) |-> ($past(cnt) == $past(act_half)));

  // R4
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_width == '0) ||
    ({1'b0, act_width} + {1'b0, act_dead} <= {1'b0, act_half}));

  // R6
  boundary_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_width) |-> (cnt == '0));

  // R7
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_width == '0) |=> (!pwm_a && !pwm_b));

  // R9
  ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready);
endmodule

bind dual_phase_pwm dual_phase_pwm_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .cfg_ready  (cfg_ready),
  .pwm_a      (pwm_a),
  .pwm_b      (pwm_b),
  .cnt        (cnt),
  .act_period (act_period),
  .act_half   (act_half),
  .act_width  (act_width),
  .act_dead   (act_dead)
);

// File: tb/dual_phase_pwm_test.sv
module dual_phase_pwm_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int NVEC = 8;

  // columns: period, width, dead, expected period, expected width, expected dead
  localparam int VEC [NVEC][6] = '{
    '{16,  4,  1, 16,  4, 1},
    '{20,  9,  2, 20,  8, 2},
    '{17,  5,  1, 16,  5, 1},
    '{24, 12,  0, 24, 11, 1},
    '{40,  3,  5, 40,  3, 5},
    '{ 2,  3,  1,  4,  1, 1},
    '{30, 20, 20, 30,  0, 20},
    '{16,  0,  1, 16,  0, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [1:0] cfg_sel = 2'd0;
  logic [CW-1:0] cfg_data = '0;
  logic pwm_a, pwm_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_alen, m_blen, m_per, m_off, m_ovl, m_gap, m_ahi, m_bhi;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_phase_pwm #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int data);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_sel   = 2'(sel);
    cfg_data  = CW'(data);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic measure(input int ncyc);
    bit pa = 1'b0, pb = 1'b0, a, b, gap_ok = 1'b0, at = 1'b0, bt = 1'b0;
    int ar = -1, gap = 0, arun = 0, brun = 0;
    m_alen = -1; m_blen = -1; m_per = -1; m_off = -1;
    m_ovl = 0; m_gap = 1000000; m_ahi = 0; m_bhi = 0;
    for (int t = 0; t < ncyc; t++) begin
      @(negedge clk);
      a = pwm_a; b = pwm_b;
      if (a && b) m_ovl++;
      if (a) m_ahi++;
      if (b) m_bhi++;
      if ((a && !pa) || (b && !pb)) begin
        if (gap_ok && gap < m_gap) m_gap = gap;
        gap = 0;
      end else if ((!a && pa) || (!b && pb)) begin
        gap_ok = 1'b1;
        gap = (!a && !b) ? 1 : 0;
      end else if (!a && !b) begin
        gap++;
      end
      if (a && !pa) begin
        if (ar >= 0) m_per = t - ar;
        ar = t; at = 1'b1; arun = 0;
      end
      if (b && !pb) begin
        if (ar >= 0) m_off = t - ar;
        bt = 1'b1; brun = 0;
      end
      if (a) arun++;
      if (b) brun++;
      if (!a && pa && at) m_alen = arun;
      if (!b && pb && bt) m_blen = brun;
      pa = a; pb = b;
    end
  endtask

  task automatic pulse_len(input bit phase_b, output int len);
    len = 0;
    do @(negedge clk); while ((phase_b ? pwm_b : pwm_a) == 1'b0);
    while ((phase_b ? pwm_b : pwm_a) == 1'b1) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 pwm_a low in reset", pwm_a == 1'b0, pwm_a, 0);
    check("R10 pwm_b low in reset", pwm_b == 1'b0, pwm_b, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 cfg_ready high", cfg_ready == 1'b1, cfg_ready, 1);
    en = 1'b1;
    measure(48);
    check("R10 default width 0 keeps A low", m_ahi == 0, m_ahi, 0);
    check("R10 default width 0 keeps B low", m_bhi == 0, m_bhi, 0);

    // table walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      en = 1'b0;
      cfg_write(0, VEC[v][0]);
      cfg_write(1, VEC[v][1]);
      cfg_write(2, VEC[v][2]);
      @(negedge clk);
      en = 1'b1;
      measure(4 * VEC[v][3] + 4);
      check("R5 no overlap", m_ovl == 0, m_ovl, 0);
      if (VEC[v][4] == 0) begin
        check("R7 zero width A low", m_ahi == 0, m_ahi, 0);
        check("R7 zero width B low", m_bhi == 0, m_bhi, 0);
      end else begin
        check("R2 R4 A width", m_alen == VEC[v][4], m_alen, VEC[v][4]);
        check("R3 R4 B width", m_blen == VEC[v][4], m_blen, VEC[v][4]);
        check("R1 R2 A period", m_per == VEC[v][3], m_per, VEC[v][3]);
        check("R3 B offset", m_off == VEC[v][3] / 2, m_off, VEC[v][3] / 2);
        check("R5 dead gap", m_gap >= VEC[v][5], m_gap, VEC[v][5]);
      end
    end

    // R6: mid-period write waits for the wrap
    @(negedge clk);
    en = 1'b0;
    cfg_write(0, 16);
    cfg_write(1, 4);
    cfg_write(2, 1);
    @(negedge clk);
    en = 1'b1;
    do @(negedge clk); while (!pwm_a);
    while (pwm_a) @(negedge clk);
    cfg_write(1, 6);
    pulse_len(1'b1, len);
    check("R6 B keeps old width this period", len == 4, len, 4);
    pulse_len(1'b0, len);
    check("R6 A takes new width next period", len == 6, len, 6);
    pulse_len(1'b1, len);
    check("R6 B takes new width next period", len == 6, len, 6);

    // R8: disable mid-pulse, then restart
    do @(negedge clk); while (!pwm_a);
    en = 1'b0;
    @(negedge clk);
    check("R8 A off after disable", pwm_a == 1'b0, pwm_a, 0);
    check("R8 B off after disable", pwm_b == 1'b0, pwm_b, 0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check("R8 A rises on first enabled edge", pwm_a == 1'b1, pwm_a, 1);
    len = 0;
    while (pwm_a) begin
      len++;
      @(negedge clk);
    end
    check("R8 first pulse full width", len == 6, len, 6);

    // R9: select 3 is ignored
    en = 1'b0;
    cfg_write(3, 2);
    @(negedge clk);
    en = 1'b1;
    measure(40);
    check("R9 select 3 leaves width", m_alen == 6, m_alen, 6);
    check("R9 select 3 leaves period", m_per == 16, m_per, 16);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule